// File: doc/BRIEF.md
# Programmable clock output generator

The block drives three independent divided clock outputs from four source clocks. All logic runs in one fast clock domain. Each source clock arrives as a one-cycle pulse on `src_pulse_i`, and each output leaves as a one-cycle tick on `tick_o`. For every output, a small configuration register chooses one of the four sources and a power-of-two division ratio from 1 to 64.

Software uses a flat register port with a combinational read. It switches outputs on through a write-one-to-set register and off through a write-one-to-clear register, and it can read back which outputs are on. An output becomes usable only after a short warm-up on its selected source. At that point its ready flag sets. Software can poll the ready flag or take an interrupt through a per-output mask, which has its own set and clear registers.

To change an output's source or ratio, software first switches the output off. It then rewrites the configuration, switches the output back on and waits for ready again.

Top module: `prog_clk_gen`

## Requirements
- R1: After reset, every output is off and not ready, every configuration reads 0 (slow source, divide by 1), the interrupt mask reads 0 and `irq_o` is low. Reads of unused or write-only addresses return 0.
- R2: A write to address 0 turns on each output whose data bit (bit i for output i) is 1. Zero bits have no effect. Address 2 reads the on/off state in bits [2:0].
- R3: A write to address 1 turns off each output whose data bit is 1. Zero bits have no effect.
- R4: The configuration of output i is at address 8+i. Bits [1:0] select the source, and that value is the index into `src_pulse_i`: 0 slow, 1 main, 2 PLL A, 3 PLL B.
- R5: Configuration bits [4:2] hold a prescaler code n. Codes 0 to 6 divide by 2^n. Code 7 divides by 64.
- R6: Once an output is on, its ready flag (address 3, bit i) sets at the clock edge that takes the second selected-source pulse after the on-write edge. No tick appears while the output is not ready.
- R7: Turning an output off clears its ready flag and its divider at that edge. No tick follows until ready sets again.
- R8: A write to an output's configuration while that output is on is ignored, and the stored value reads back unchanged.
- R9: Writing 1s to address 4 sets mask bits, and writing 1s to address 5 clears them. Address 6 reads the mask. `irq_o` is high exactly when some output is both ready and masked in.
- R10: After ready sets, the k-th following selected-source pulse (k from 1) raises the tick in the same cycle when k is a multiple of the ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| src_pulse_i | input | 4 | Source clock pulses: slow, main, PLL A, PLL B |
| tick_o | output | 3 | Divided output ticks, one per output |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest cases to reach are the coincidences at the edges of the warm-up and divider windows. One is an off-write that lands in the same cycle as the pulse that would set ready or raise a tick. Another is a configuration write that arrives while the output is still on. A third is a divide-by-64 or reserved-code output that has to run long enough to wrap its divider. The stimulus reaches these through directed sequences followed by a long random mix. In that mix, every source pulses densely and register writes to the control, mask and configuration addresses arrive at random. A bench model predicts every tick, the interrupt and every read, cycle by cycle.

// File: rtl/prog_clk_pkg.sv
package prog_clk_pkg;
  localparam int AW     = 4;
  localparam int DW     = 8;
  localparam int SRC_W  = 2;
  localparam int PRES_W = 3;
  localparam int CNT_W  = 6;   // log2 of the largest ratio
  localparam int WARM   = 2;   // source pulses before ready

  localparam logic [AW-1:0] A_ON   = 4'h0;
  localparam logic [AW-1:0] A_OFF  = 4'h1;
  localparam logic [AW-1:0] A_STAT = 4'h2;
  localparam logic [AW-1:0] A_RDY  = 4'h3;
  localparam logic [AW-1:0] A_IE   = 4'h4;
  localparam logic [AW-1:0] A_ID   = 4'h5;
  localparam logic [AW-1:0] A_IM   = 4'h6;
  localparam logic [AW-1:0] A_CFG0 = 4'h8;

  typedef struct packed {
    logic [PRES_W-1:0] pres;
    logic [SRC_W-1:0]  src;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/prog_clk_presc.sv
module prog_clk_presc
  import prog_clk_pkg::*;
(
  input  logic [PRES_W-1:0] code_i,
  output logic [CNT_W-1:0]  term_o
);
  localparam int MAX_CODE = CNT_W;

  logic [PRES_W-1:0] code_sat;

  always_comb begin
    code_sat = (int'(code_i) > MAX_CODE) ? PRES_W'(MAX_CODE) : code_i;
    term_o   = CNT_W'((32'd1 << code_sat) - 32'd1);
  end
endmodule

// File: rtl/prog_clk_chan.sv
module prog_clk_chan
  import prog_clk_pkg::*;
#(
  parameter int NUM_SRC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_q_i,
  input  logic               en_nxt_i,
  input  cfg_t               cfg_i,
  input  logic [NUM_SRC-1:0] src_pulse_i,
  output logic               rdy_o,
  output logic               tick_o
);
  localparam int WC_W = $clog2(WARM + 1);

  logic             src_hit;
  logic [CNT_W-1:0] term;
  logic [CNT_W-1:0] cnt_q;
  logic [WC_W-1:0]  wc_q;

  assign src_hit = src_pulse_i[cfg_i.src];

  prog_clk_presc u_presc (
    .code_i (cfg_i.pres),
    .term_o (term)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wc_q  <= '0;
      rdy_o <= 1'b0;
      cnt_q <= '0;
    end else if (!en_nxt_i) begin
      wc_q  <= '0;
      rdy_o <= 1'b0;
      cnt_q <= '0;
    end else if (en_q_i && src_hit) begin
      if (!rdy_o) begin
        wc_q <= wc_q + 1'b1;
        if (wc_q == WC_W'(WARM - 1)) rdy_o <= 1'b1;
      end else begin
        cnt_q <= (cnt_q == term) ? '0 : cnt_q + 1'b1;
      end
    end
  end

  assign tick_o = rdy_o && src_hit && (cnt_q == term);
endmodule

// File: rtl/prog_clk_regs.sv
module prog_clk_regs
  import prog_clk_pkg::*;
#(
  parameter int NUM_OUT = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [DW-1:0]        wdata_i,
  input  logic [NUM_OUT-1:0]   rdy_i,
  output logic [DW-1:0]        rdata_o,
  output logic [NUM_OUT-1:0]   en_q_o,
  output logic [NUM_OUT-1:0]   en_nxt_o,
  output logic [NUM_OUT-1:0]   mask_q_o,
  output cfg_t [NUM_OUT-1:0]   cfg_q_o
);
  logic [NUM_OUT-1:0] on_b, off_b, ie_b, id_b;

  assign on_b  = (we_i && addr_i == A_ON)  ? wdata_i[NUM_OUT-1:0] : '0;
  assign off_b = (we_i && addr_i == A_OFF) ? wdata_i[NUM_OUT-1:0] : '0;
  assign ie_b  = (we_i && addr_i == A_IE)  ? wdata_i[NUM_OUT-1:0] : '0;
  assign id_b  = (we_i && addr_i == A_ID)  ? wdata_i[NUM_OUT-1:0] : '0;

  assign en_nxt_o = (en_q_o | on_b) & ~off_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q_o   <= '0;
      mask_q_o <= '0;
    end else begin
      en_q_o   <= en_nxt_o;
      mask_q_o <= (mask_q_o | ie_b) & ~id_b;
    end
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_cfg
    localparam logic [AW-1:0] CA = AW'(int'(A_CFG0) + g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               cfg_q_o[g] <= '0;
      else if (we_i && addr_i == CA && !en_q_o[g]) cfg_q_o[g] <= wdata_i[CFG_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_STAT:  rdata_o[NUM_OUT-1:0] = en_q_o;
      A_RDY:   rdata_o[NUM_OUT-1:0] = rdy_i;
      A_IM:    rdata_o[NUM_OUT-1:0] = mask_q_o;
      default: ;
    endcase
    for (int i = 0; i < NUM_OUT; i++) begin
      if (addr_i == AW'(int'(A_CFG0) + i)) rdata_o[CFG_W-1:0] = cfg_q_o[i];
    end
  end
endmodule

// File: rtl/prog_clk_gen.sv
module prog_clk_gen
  import prog_clk_pkg::*;
#(
  parameter int NUM_OUT = 3,
  parameter int NUM_SRC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [3:0]         addr_i,
  input  logic [7:0]         wdata_i,
  output logic [7:0]         rdata_o,
  input  logic [NUM_SRC-1:0] src_pulse_i,
  output logic [NUM_OUT-1:0] tick_o,
  output logic               irq_o
);
  logic [NUM_OUT-1:0] en_q, en_nxt, mask_q, rdy;
  cfg_t [NUM_OUT-1:0] cfg_q;

  prog_clk_regs #(.NUM_OUT(NUM_OUT)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdy_i    (rdy),
    .rdata_o  (rdata_o),
    .en_q_o   (en_q),
    .en_nxt_o (en_nxt),
    .mask_q_o (mask_q),
    .cfg_q_o  (cfg_q)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_chan
    prog_clk_chan #(.NUM_SRC(NUM_SRC)) u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .en_q_i      (en_q[g]),
      .en_nxt_i    (en_nxt[g]),
      .cfg_i       (cfg_q[g]),
      .src_pulse_i (src_pulse_i),
      .rdy_o       (rdy[g]),
      .tick_o      (tick_o[g])
    );
  end

  assign irq_o = |(rdy & mask_q);
endmodule

// File: rtl/prog_clk_gen_chk.sv
module prog_clk_gen_chk
  import prog_clk_pkg::*;
#(
  parameter int NUM_OUT = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_OUT-1:0] en_i,
  input logic [NUM_OUT-1:0] rdy_i,
  input logic [NUM_OUT-1:0] tick_i,
  input logic [NUM_OUT-1:0] mask_i,
  input cfg_t [NUM_OUT-1:0] cfg_i,
  input logic               irq_i
);
  // R6
  rdy_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_i & ~en_i) == '0);

  // R6
  tick_needs_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i & ~rdy_i) == '0);

  // R9
  irq_rise_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> (rdy_i & mask_i) != '0);

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_ch
    // R7
    off_clears_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(en_i[g]) |-> !rdy_i[g]);

    // R8
    cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i[g] && $past(en_i[g])) |-> $stable(cfg_i[g]));

    // R6
    rdy_rise_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rdy_i[g]) |-> $past(en_i[g]));
  end
endmodule

bind prog_clk_gen prog_clk_gen_chk #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_q),
  .rdy_i  (rdy),
  .tick_i (tick_o),
  .mask_i (mask_q),
  .cfg_i  (cfg_q),
  .irq_i  (irq_o)
);

// File: tb/prog_clk_gen_bench.sv
module prog_clk_gen_bench;
  localparam int N = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [3:0] src = '0;
  logic [N-1:0] tick;
  logic       irq;

  always #2 clk = ~clk;

  prog_clk_gen u_prog_clk_gen (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .we_i        (we),
    .addr_i      (addr),
    .wdata_i     (wdata),
    .rdata_o     (rdata),
    .src_pulse_i (src),
    .tick_o      (tick),
    .irq_o       (irq)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  string cur = "R1";

  logic [N-1:0] m_en = '0, m_rdy = '0, m_mask = '0;
  int           m_wc[N];
  int           m_cnt[N];
  logic [4:0]   m_cfg[N];

  function automatic int term_f(logic [2:0] code);
    int c = (int'(code) > 6) ? 6 : int'(code);
    return (1 << c) - 1;
  endfunction

  function automatic logic [7:0] exp_rd(logic [3:0] a);
    logic [7:0] r = '0;
    case (a)
      4'h2: r[N-1:0] = m_en;
      4'h3: r[N-1:0] = m_rdy;
      4'h6: r[N-1:0] = m_mask;
      4'h8: r[4:0] = m_cfg[0];
      4'h9: r[4:0] = m_cfg[1];
      4'hA: r[4:0] = m_cfg[2];
      default: ;
    endcase
    return r;
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", cur, what, act, exp);
    end
  endtask

  task automatic step(logic w, logic [3:0] a, logic [7:0] d, logic [3:0] s);
    logic [N-1:0] on_b, off_b, en_n, exp_t;
    @(negedge clk);
    we = w; addr = a; wdata = d; src = s;
    #1;
    for (int c = 0; c < N; c++)
      exp_t[c] = m_rdy[c] && s[m_cfg[c][1:0]] && (m_cnt[c] == term_f(m_cfg[c][4:2]));
    chk("tick", 32'(tick), 32'(exp_t));
    chk("irq", 32'(irq), 32'(|(m_rdy & m_mask)));
    if (!w) chk("rdata", 32'(rdata), 32'(exp_rd(a)));
    @(posedge clk);
    on_b  = (w && a == 4'h0) ? d[N-1:0] : '0;
    off_b = (w && a == 4'h1) ? d[N-1:0] : '0;
    en_n  = (m_en | on_b) & ~off_b;
    for (int c = 0; c < N; c++) begin
      if (!en_n[c]) begin
        m_rdy[c] = 1'b0; m_wc[c] = 0; m_cnt[c] = 0;
      end else if (m_en[c] && s[m_cfg[c][1:0]]) begin
        if (!m_rdy[c]) begin
          if (m_wc[c] == 1) m_rdy[c] = 1'b1;
          m_wc[c]++;
        end else begin
          m_cnt[c] = (m_cnt[c] == term_f(m_cfg[c][4:2])) ? 0 : m_cnt[c] + 1;
        end
      end
      if (w && a == 4'(8 + c) && !m_en[c]) m_cfg[c] = d[4:0];
    end
    if (w && a == 4'h4) m_mask = m_mask | d[N-1:0];
    if (w && a == 4'h5) m_mask = m_mask & ~d[N-1:0];
    m_en = en_n;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [3:0] waddr [7];
    waddr = '{4'h0, 4'h1, 4'h4, 4'h5, 4'h8, 4'h9, 4'hA};
    for (int c = 0; c < N; c++) begin m_wc[c] = 0; m_cnt[c] = 0; m_cfg[c] = '0; end
    void'($urandom(32'h5eed_0c1c));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    cur = "R1";
    for (int a = 0; a < 16; a++) step(0, 4'(a), 8'h00, 4'h0);

    cur = "R4";
    step(1, 4'h8, 8'h01, 4'h0);           // main source, divide by 1
    step(1, 4'h0, 8'h01, 4'h0);
    for (int i = 0; i < 4; i++) step(0, 4'h3, 8'h00, 4'h1);   // slow only: no warm-up
    for (int i = 0; i < 6; i++) step(0, 4'h3, 8'h00, 4'h2);   // main: ready then ticks

    cur = "R8";
    step(1, 4'h8, 8'h1F, 4'h2);
    step(0, 4'h8, 8'h00, 4'h2);

    cur = "R3";
    step(1, 4'h1, 8'h00, 4'h2);
    step(0, 4'h2, 8'h00, 4'h2);
    step(1, 4'h1, 8'h01, 4'h2);
    step(0, 4'h3, 8'h00, 4'h2);
    step(0, 4'h2, 8'h00, 4'h2);

    cur = "R5";
    step(1, 4'h8, 8'h1C, 4'h0);           // code 7, slow source
    step(1, 4'h0, 8'h01, 4'h0);
    for (int i = 0; i < 140; i++) step(0, 4'h3, 8'h00, 4'h1);

    cur = "R2";
    step(1, 4'h0, 8'h00, 4'h0);
    step(0, 4'h2, 8'h00, 4'h0);

    cur = "R9";
    step(1, 4'h4, 8'h07, 4'h0);
    step(0, 4'h6, 8'h00, 4'h0);
    step(1, 4'h5, 8'h01, 4'h0);
    step(0, 4'h6, 8'h00, 4'h0);

    cur = "R10";
    step(1, 4'h9, 8'h0B, 4'h0);           // PLL B, divide by 4
    step(1, 4'h0, 8'h02, 4'h0);
    step(1, 4'h4, 8'h02, 4'h0);
    for (int i = 0; i < 20; i++) step(0, 4'h3, 8'h00, (i % 3 == 2) ? 4'h0 : 4'h8);

    cur = "R6/R7/R10 random";
    for (int i = 0; i < 6000; i++) begin
      logic       w = ($urandom % 6) == 0;
      logic [3:0] a = w ? waddr[$urandom % 7] : 4'($urandom % 11);
      logic [7:0] d = 8'($urandom);
      logic [3:0] s = 4'($urandom);
      if (w && a >= 4'h8) d[4:2] = 3'($urandom % 8);
      step(w, a, d, s);
    end

    summary();
    $finish;
  end
endmodule